// File: doc/BRIEF.md
# Banked Register File with Memory-Mapped Window

This block holds the general-purpose byte registers of a small 8-bit accumulator machine, together with its stack pointer, status word and three control bytes. The general registers come in four banks of eight bytes. Two bits of the status word pick the bank the register port works on. A datapath reads and writes single bytes or 16-bit pairs through a numeric register code. The read path is combinational. Writes take effect on the clock edge.

All 32 bank bytes also appear as a byte-wide window in a 20-bit address space, so a load/store unit can reach any bank without switching. The banks sit in reverse order in that window: bank 0 takes the top eight bytes. A small evaluator turns the zero and carry flags, or an operand value, into a branch-taken bit.

Top module: `banked_regfile`

## Requirements
- R1: After reset every one of the 32 bank bytes holds 0x11, the status word holds 0x06, the extra-segment byte holds 0x0F, and the code-segment byte, the mode byte and the stack pointer hold 0.
- R2: The active bank is n = 2*STATUS[5] + STATUS[3]. Bank n occupies window offsets (3-n)*8 through (3-n)*8+7.
- R3: Byte codes 1 to 8 select X, A, C, B, E, D, L, H, at offsets 0 to 7 of the active bank. A byte read returns the value zero-extended to 16 bits. A byte write stores data bits 7:0.
- R4: Pair codes 9 to 12 select AX, BC, DE and HL. The first letter is the high byte and the second the low byte. A pair read returns high*256+low. A pair write stores bits 15:8 in the high byte and bits 7:0 in the low byte.
- R5: Window addresses BASE to BASE+31 (BASE = 0xFFEE0) read and write the bank byte at offset address-BASE. Outside that range a window read returns 0 and a window write changes nothing.
- R6: Code 13 is the 16-bit stack pointer. A write stores the data with bit 0 cleared. `sp_odd` is high for exactly the cycle after a stack-pointer write whose bit 0 was set, and low otherwise.
- R7: Codes 14 to 17 are the status word, the code-segment byte, the extra-segment byte and the mode byte. Writes store data bits 7:0. Reads are zero-extended.
- R8: `cond_true` depends on `cond_sel`, with Z = STATUS[6] and CY = STATUS[0]: 0 gives operand!=0, 1 gives operand==0, 2 gives CY, 3 gives !CY, 4 gives !(Z|CY), 5 gives Z|CY, 6 gives Z, 7 gives !Z.
- R9: Reading code 0 returns 0 and raises no error. Reading codes 18 to 31 returns 0 and raises `reg_err`. A write with code 0 or 18 to 31 raises `reg_err` and changes nothing.
- R10: A status-word write moves the bank selection from the next cycle. A read in the cycle of the write still uses the old bank.
- R11: If the window and the register port write the same byte in one cycle, the register-port value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel | input | 5 | Register code for the read port |
| rd_data | output | 16 | Read result, zero-extended for byte registers |
| wr_en | input | 1 | Register-port write strobe |
| wr_sel | input | 5 | Register code for the write port |
| wr_data | input | 16 | Register-port write data |
| reg_err | output | 1 | Undefined read code, or write with an invalid code |
| mm_addr | input | 20 | Window address |
| mm_wr | input | 1 | Window write strobe |
| mm_wdata | input | 8 | Window write data |
| mm_rdata | output | 8 | Window read data, 0 outside the window |
| cond_sel | input | 3 | Condition selector |
| cond_val | input | 8 | Operand for the true/false conditions |
| cond_true | output | 1 | Condition result |
| sp_odd | output | 1 | One-cycle flag after an odd stack-pointer write |

## Verification
The bench aims at the reversed bank placement. It writes through the window into banks 3 and 1 and reads the same bytes back through the register port after switching banks. A design that placed bank n at offset n*8 would return the reset pattern instead. It reads in the very cycle of a status-word write, so a design that forwarded the new bank bits would show the wrong bank's byte early. It writes the same byte from both ports at once to catch reversed priority. It writes to the address just below the window, which a design decoding only the low five address bits would wrongly accept into bank 0's H. It sweeps all eight conditions over every Z/CY combination and both zero and non-zero operands, which exposes swapped H/NH or inverted carry tests. It also makes odd and even stack-pointer writes, which expose a flag that is sticky or that ignores bit 0.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int                AW       = 20,
  parameter logic [AW-1:0]     BASE     = 20'hFFEE0,
  parameter int                NBANK    = 4,
  parameter int                BANKB    = 8,
  parameter logic [7:0]        FILL     = 8'h11,
  parameter logic [7:0]        PSW_INIT = 8'h06,
  parameter logic [7:0]        ES_INIT  = 8'h0F,
  parameter logic [7:0]        CS_INIT  = 8'h00,
  parameter logic [7:0]        PMC_INIT = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rd_sel,
  output logic [15:0] rd_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic        reg_err,
  input  logic [AW-1:0] mm_addr,
  input  logic        mm_wr,
  input  logic [7:0]  mm_wdata,
  output logic [7:0]  mm_rdata,
  input  logic [2:0]  cond_sel,
  input  logic [7:0]  cond_val,
  output logic        cond_true,
  output logic        sp_odd
);
  localparam int NBYTES = NBANK * BANKB;
  localparam int SW     = $clog2(NBANK);
  localparam int BW     = $clog2(BANKB);
  localparam int OFFW   = SW + BW;

  localparam logic [4:0] C_NONE = 5'd0,  C_X   = 5'd1,  C_H   = 5'd8;
  localparam logic [4:0] C_AX   = 5'd9,  C_HL  = 5'd12, C_SP  = 5'd13;
  localparam logic [4:0] C_PSW  = 5'd14, C_CS  = 5'd15, C_ES  = 5'd16;
  localparam logic [4:0] C_PMC  = 5'd17, C_LAST = C_PMC;

  logic [7:0]  rf [0:NBYTES-1];
  logic [7:0]  psw_q, cs_q, es_q, pmc_q;
  logic [15:0] sp_q;
  logic        sp_odd_q;

  wire [SW-1:0] bank = {psw_q[5], psw_q[3]};
  wire [SW-1:0] slot = ~bank;
  wire          flag_z  = psw_q[6];
  wire          flag_cy = psw_q[0];

  wire [BW-1:0] rd_boff = rd_sel[BW-1:0] - BW'(1);
  wire [BW-2:0] rd_poff = rd_sel[BW-2:0] - (BW-1)'(1);
  wire [BW-1:0] wr_boff = wr_sel[BW-1:0] - BW'(1);
  wire [BW-2:0] wr_poff = wr_sel[BW-2:0] - (BW-1)'(1);

  wire            mm_hit = (mm_addr[AW-1:OFFW] == BASE[AW-1:OFFW]);
  wire [OFFW-1:0] mm_off = mm_addr[OFFW-1:0];

  assign mm_rdata = mm_hit ? rf[mm_off] : 8'h00;
  assign sp_odd   = sp_odd_q;
  assign reg_err  = (rd_sel > C_LAST) ||
                    (wr_en && (wr_sel == C_NONE || wr_sel > C_LAST));

  always_comb begin
    case (rd_sel) inside
      [C_X:C_H]:   rd_data = {8'h00, rf[{slot, rd_boff}]};
      [C_AX:C_HL]: rd_data = {rf[{slot, rd_poff, 1'b1}], rf[{slot, rd_poff, 1'b0}]};
      C_SP:        rd_data = sp_q;
      C_PSW:       rd_data = {8'h00, psw_q};
      C_CS:        rd_data = {8'h00, cs_q};
      C_ES:        rd_data = {8'h00, es_q};
      C_PMC:       rd_data = {8'h00, pmc_q};
      default:     rd_data = 16'h0000;
    endcase
  end

  always_comb begin
    case (cond_sel)
      3'd0: cond_true = (cond_val != 8'h00);
      3'd1: cond_true = (cond_val == 8'h00);
      3'd2: cond_true = flag_cy;
      3'd3: cond_true = !flag_cy;
      3'd4: cond_true = !(flag_z | flag_cy);
      3'd5: cond_true = flag_z | flag_cy;
      3'd6: cond_true = flag_z;
      default: cond_true = !flag_z;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) rf[i] <= FILL;
      psw_q    <= PSW_INIT;
      cs_q     <= CS_INIT;
      es_q     <= ES_INIT;
      pmc_q    <= PMC_INIT;
      sp_q     <= 16'h0000;
      sp_odd_q <= 1'b0;
    end else begin
      sp_odd_q <= 1'b0;
      if (mm_wr && mm_hit) rf[mm_off] <= mm_wdata;
      if (wr_en) begin
        case (wr_sel) inside
          [C_X:C_H]: rf[{slot, wr_boff}] <= wr_data[7:0];
          [C_AX:C_HL]: begin
            rf[{slot, wr_poff, 1'b1}] <= wr_data[15:8];
            rf[{slot, wr_poff, 1'b0}] <= wr_data[7:0];
          end
          C_SP: begin
            sp_q     <= {wr_data[15:1], 1'b0};
            sp_odd_q <= wr_data[0];
          end
          C_PSW:   psw_q <= wr_data[7:0];
          C_CS:    cs_q  <= wr_data[7:0];
          C_ES:    es_q  <= wr_data[7:0];
          C_PMC:   pmc_q <= wr_data[7:0];
          default: ;
        endcase
      end
    end
  end

  a_r4_pair_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == C_AX) |=>
      (rf[{~$past(bank), BW'(1)}] == $past(wr_data[15:8]) &&
       rf[{~$past(bank), BW'(0)}] == $past(wr_data[7:0])));

  a_r6_sp_even: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == C_SP) |=>
      (sp_q == {$past(wr_data[15:1]), 1'b0} && sp_odd == $past(wr_data[0])));

  a_r10_bank_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == C_PSW) |=>
      (bank == {$past(wr_data[5]), $past(wr_data[3])}));

  a_r11_port_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == C_X && mm_wr && mm_hit && mm_off == {slot, BW'(0)}) |=>
      (rf[$past(mm_off)] == $past(wr_data[7:0])));

  a_r9_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel > C_LAST) |-> (rd_data == 16'h0000 && reg_err));
endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
  localparam logic [19:0] BASE = 20'hFFEE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        reg_err;
  logic [19:0] mm_addr = '0;
  logic        mm_wr = 1'b0;
  logic [7:0]  mm_wdata = '0;
  logic [7:0]  mm_rdata;
  logic [2:0]  cond_sel = '0;
  logic [7:0]  cond_val = '0;
  logic        cond_true;
  logic        sp_odd;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .reg_err(reg_err),
    .mm_addr(mm_addr), .mm_wr(mm_wr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .cond_sel(cond_sel), .cond_val(cond_val), .cond_true(cond_true), .sp_odd(sp_odd)
  );

  // {write code, write data, read code, expected read}, all in bank 0
  localparam logic [41:0] VEC [12] = '{
    {5'd1,  16'h003C, 5'd1,  16'h003C},
    {5'd9,  16'hBEEF, 5'd2,  16'h00BE},
    {5'd3,  16'h0042, 5'd1,  16'h00EF},
    {5'd4,  16'h0099, 5'd10, 16'h9942},
    {5'd11, 16'h1357, 5'd5,  16'h0057},
    {5'd7,  16'h00A5, 5'd6,  16'h0013},
    {5'd8,  16'h005A, 5'd12, 16'h5AA5},
    {5'd15, 16'h0003, 5'd15, 16'h0003},
    {5'd16, 16'h0001, 5'd16, 16'h0001},
    {5'd17, 16'h0001, 5'd17, 16'h0001},
    {5'd13, 16'hFFE0, 5'd13, 16'hFFE0},
    {5'd10, 16'h7E81, 5'd3,  16'h0081}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [4:0] sel);
    rd_sel = sel; #1;
  endtask

  task automatic mm_write(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    mm_addr = a; mm_wdata = d; mm_wr = 1'b1;
    @(negedge clk);
    mm_wr = 1'b0;
    #1;
  endtask

  task automatic mm_read(input logic [19:0] a);
    mm_addr = a; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(5'd1);  chk("R1 X", rd_data, 16'h0011);
    rd(5'd12); chk("R1 HL", rd_data, 16'h1111);
    rd(5'd14); chk("R1 status", rd_data, 16'h0006);
    rd(5'd16); chk("R1 ES", rd_data, 16'h000F);
    rd(5'd15); chk("R1 CS", rd_data, 16'h0000);
    rd(5'd17); chk("R1 mode", rd_data, 16'h0000);
    rd(5'd13); chk("R1 SP", rd_data, 16'h0000);
    chk("R1 sp_odd", {15'd0, sp_odd}, 16'h0000);
    mm_read(BASE + 20'd7); chk("R1 window byte", {8'h00, mm_rdata}, 16'h0011);

    // R3 R4 R7 vector walk
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][41:37], VEC[i][36:21]);
      rd(VEC[i][20:16]);
      chk($sformatf("R3 R4 R7 vector %0d", i), rd_data, VEC[i][15:0]);
    end

    // R5 / R2 window placement: bank 0 at offsets 24..31
    mm_read(BASE + 20'd24); chk("R5 R2 bank0 X", {8'h00, mm_rdata}, 16'h00EF);
    mm_read(BASE + 20'd25); chk("R5 R2 bank0 A", {8'h00, mm_rdata}, 16'h00BE);
    mm_read(BASE + 20'd31); chk("R5 R2 bank0 H", {8'h00, mm_rdata}, 16'h005A);
    mm_read(BASE + 20'd32); chk("R5 outside read", {8'h00, mm_rdata}, 16'h0000);
    mm_write(BASE - 20'd1, 8'hC3);
    rd(5'd8); chk("R5 outside write ignored", rd_data, 16'h005A);
    mm_write(BASE, 8'h77);

    // R10 status write: same-cycle read uses old bank
    @(negedge clk);
    wr_sel = 5'd14; wr_data = 16'h0028; wr_en = 1'b1; rd_sel = 5'd1;
    #1; chk("R10 old bank in write cycle", rd_data, 16'h00EF);
    @(negedge clk);
    wr_en = 1'b0; #1;
    chk("R2 R10 bank3 X via window", rd_data, 16'h0077);
    mm_read(BASE + 20'd8); chk("R2 bank2 untouched", {8'h00, mm_rdata}, 16'h0011);

    wr(5'd14, 16'h0008);
    mm_write(BASE + 20'd17, 8'h5E);
    rd(5'd2); chk("R2 bank1 A", rd_data, 16'h005E);
    wr(5'd14, 16'h0020);
    rd(5'd9); chk("R2 bank2 AX reset", rd_data, 16'h1111);
    wr(5'd14, 16'h0000);
    rd(5'd9); chk("R2 back to bank0 AX", rd_data, 16'hBEEF);

    // R11 collision
    @(negedge clk);
    wr_sel = 5'd1; wr_data = 16'h0055; wr_en = 1'b1;
    mm_addr = BASE + 20'd24; mm_wdata = 8'hAA; mm_wr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; mm_wr = 1'b0; #1;
    rd(5'd1); chk("R11 register port wins", rd_data, 16'h0055);
    chk("R11 window view", {8'h00, mm_rdata}, 16'h0055);

    // R6 stack pointer
    wr(5'd13, 16'h1235);
    rd(5'd13); chk("R6 odd SP cleared", rd_data, 16'h1234);
    chk("R6 sp_odd pulse", {15'd0, sp_odd}, 16'h0001);
    @(negedge clk); #1;
    chk("R6 sp_odd one cycle", {15'd0, sp_odd}, 16'h0000);
    wr(5'd13, 16'h2000);
    chk("R6 even SP no flag", {15'd0, sp_odd}, 16'h0000);
    rd(5'd13); chk("R6 even SP", rd_data, 16'h2000);

    // R8 condition sweep
    for (int p = 0; p < 4; p++) begin
      logic z, cy;
      z = p[1]; cy = p[0];
      wr(5'd14, {8'h00, 1'b0, z, 5'b00000, cy});
      for (int v = 0; v < 2; v++) begin
        for (int c = 0; c < 8; c++) begin
          logic e;
          cond_val = (v == 0) ? 8'h00 : 8'h80;
          cond_sel = 3'(c);
          case (c)
            0: e = (v != 0);
            1: e = (v == 0);
            2: e = cy;
            3: e = !cy;
            4: e = !(z | cy);
            5: e = z | cy;
            6: e = z;
            default: e = !z;
          endcase
          #1;
          chk($sformatf("R8 cond %0d z=%0d cy=%0d val=%0d", c, z, cy, v),
              {15'd0, cond_true}, {15'd0, e});
        end
      end
    end
    wr(5'd14, 16'h0000);

    // R9 none and undefined codes
    rd(5'd0);  chk("R9 none reads 0", rd_data, 16'h0000);
    chk("R9 none no error", {15'd0, reg_err}, 16'h0000);
    rd(5'd20); chk("R9 undefined reads 0", rd_data, 16'h0000);
    chk("R9 undefined read error", {15'd0, reg_err}, 16'h0001);
    rd(5'd1);
    @(negedge clk);
    wr_sel = 5'd0; wr_data = 16'h0000; wr_en = 1'b1; #1;
    chk("R9 write none error", {15'd0, reg_err}, 16'h0001);
    wr_sel = 5'd25; #1;
    chk("R9 write undefined error", {15'd0, reg_err}, 16'h0001);
    @(negedge clk);
    wr_en = 1'b0; #1;
    rd(5'd1);  chk("R9 X unchanged", rd_data, 16'h0055);
    rd(5'd12); chk("R9 HL unchanged", rd_data, 16'h5AA5);
    rd(5'd14); chk("R9 status unchanged", rd_data, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule